// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command, address, bank, clock-enable and byte-mask pins of one 32-bit SDRAM from reset until the memory is ready for use. First it keeps the device quiet for the power-up stabilization interval. It then closes every bank and waits for the banks to go idle. Next it issues a burst of auto-refresh commands and programs the mode register. Last it waits out the mode-register delay and raises a ready flag, which hands the bus over to the normal-operation controller.

All delays are given in nanoseconds and converted to clock cycles with a clock-frequency parameter in MHz, rounding up. A parameter chooses how the banks are closed: one precharge-all command, or one precharge per bank. The target device has 13 row address lines, two bank-select lines, 8 column bits and a four-lane byte mask.

Top module: `sdram_init_seq`

## Requirements
- R1: Commands appear on {cs_n, ras_n, cas_n, we_n} with these encodings: NOP = 0111, precharge = 0010, auto-refresh = 0001, mode-register set = 0000. The reset is synchronous and active high. On each cycle after a clock edge that samples it high, the pins show NOP, CKE is 1, every DQM line is 1 and init_done is 0. CKE and all DQM lines stay at 1 for the whole sequence.
- R2: Let H = ceil(HOLD_NS * CLK_MHZ / 1000), and call the cycle right after the last reset edge cycle 0. The pins carry NOP for cycles 0 to H. The first precharge appears at cycle H+1.
- R3: With PRECHARGE_ALL = 1, a single precharge is issued with A10 = 1, all other address bits 0 and bank 0. With PRECHARGE_ALL = 0, one precharge per bank is issued on consecutive cycles, for banks 0, 1, 2 and 3 in that order, with the address all zero.
- R4: The first auto-refresh comes exactly TRP_CYC = ceil(TRP_NS * CLK_MHZ / 1000) cycles after the last precharge, with NOP in between.
- R5: Exactly NUM_REFRESH auto-refresh commands are issued. A value below 8 is rejected at elaboration.
- R6: Consecutive auto-refresh commands are exactly TRFC_CYC = ceil(TRFC_NS * CLK_MHZ / 1000) cycles apart, with NOP on the cycles between them.
- R7: The mode-register set comes TRFC_CYC cycles after the last auto-refresh. It carries MODE_VAL on the address bus and 0 on the bank bits.
- R8: init_done rises exactly TMRD_CYC cycles after the mode-register set, with NOP in between. After that, init_done stays 1 and the pins stay at NOP until the next reset.
- R9: A reset at any point, including in the middle of the refresh burst or after init_done is high, drops init_done and restarts the whole sequence from the hold period with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state and pins |
| rst | input | 1 | Synchronous active-high restart |
| sdram_cke | output | 1 | Clock enable to the memory |
| sdram_cs_n | output | 1 | Chip select, active low |
| sdram_ras_n | output | 1 | Row strobe, active low |
| sdram_cas_n | output | 1 | Column strobe, active low |
| sdram_we_n | output | 1 | Write enable, active low |
| sdram_ba | output | BANK_W | Bank select |
| sdram_addr | output | ROW_W | Multiplexed address lines |
| sdram_dqm | output | DQM_W | Byte-lane masks, held high |
| init_done | output | 1 | Sequence complete, bus handed over |

## Verification
The scoreboard predicts the exact cycle of every command and of the rising edge of the ready flag, so the checks are exact-cycle checks. A design that leaves the hold one cycle early, or that waits one cycle too long or too short between refreshes, shows up as a cycle mismatch. A design that counts one refresh too few or too many shows up as a missing or unexpected queue item. Two instances are checked. The per-bank instance shows whether the bank order is wrong or A10 is set on single-bank precharges. The precharge-all instance shows whether A10 is dropped. Resets are applied in the middle of the refresh burst and while the ready flag is high. They show whether a design keeps a stale refresh count, fails to clear the ready flag, or resumes from some point other than the hold.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   // command encodings on {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdram_cmd_e;

   typedef enum logic [2:0] {
      ST_HOLD,
      ST_PRE,
      ST_TRP,
      ST_REF,
      ST_TRFC,
      ST_MRS,
      ST_TMRD,
      ST_DONE
   } init_state_e;

   // nanoseconds to clock cycles, rounded up
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
      return (ns * mhz + 32'd999) / 32'd1000;
   endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_width
      $error("timer width out of range");
   end
   if ((64'(RST_VAL) >> CNT_W) != 64'd0) begin : g_bad_rst
      $error("timer reset value does not fit");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= CNT_W'(RST_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   AST_TMR_STAYS_EXPIRED: assert property (@(posedge clk) disable iff (rst)
      (expired && !load) |=> expired); // R2

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
   import sdram_init_pkg::*;
#(
   parameter int unsigned HOLD_CYC      = 50000,
   parameter int unsigned TRP_CYC       = 5,
   parameter int unsigned TRFC_CYC      = 18,
   parameter int unsigned TMRD_CYC      = 2,
   parameter int unsigned NUM_REFRESH   = 8,
   parameter bit          PRECHARGE_ALL = 1'b1,
   parameter int unsigned BANK_W        = 2
) (
   input  logic              clk,
   input  logic              rst,
   output init_state_e       state,
   output logic [BANK_W-1:0] bank
);

   localparam int unsigned NUM_BANKS = 1 << BANK_W;
   localparam int unsigned TMR_W     = $clog2(HOLD_CYC + TRP_CYC + TRFC_CYC + TMRD_CYC + 1);
   localparam int unsigned REF_W     = $clog2(NUM_REFRESH + 1);

   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_exp;
   logic             last_pre;
   logic [REF_W-1:0] ref_cnt;

   // each wait is entered one cycle after its command, so load N-2
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state)
         ST_PRE: begin
            tmr_load = last_pre;
            tmr_val  = TMR_W'(TRP_CYC - 2);
         end
         ST_REF: begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TRFC_CYC - 2);
         end
         ST_MRS: begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TMRD_CYC - 2);
         end
         default: ;
      endcase
   end

   sdram_init_timer #(
      .CNT_W   (TMR_W),
      .RST_VAL (HOLD_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   if (PRECHARGE_ALL) begin : g_pre_all
      assign last_pre = 1'b1;
   end else begin : g_pre_bank
      assign last_pre = (bank == BANK_W'(NUM_BANKS - 1));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_HOLD;
         bank    <= '0;
         ref_cnt <= '0;
      end else begin
         case (state)
            ST_HOLD: if (tmr_exp) state <= ST_PRE;
            ST_PRE: begin
               if (last_pre) state <= ST_TRP;
               else          bank  <= bank + 1'b1;
            end
            ST_TRP:  if (tmr_exp) state <= ST_REF;
            ST_REF: begin
               ref_cnt <= ref_cnt + 1'b1;
               state   <= ST_TRFC;
            end
            ST_TRFC: begin
               if (tmr_exp)
                  state <= (ref_cnt == REF_W'(NUM_REFRESH)) ? ST_MRS : ST_REF;
            end
            ST_MRS:  state <= ST_TMRD;
            ST_TMRD: if (tmr_exp) state <= ST_DONE;
            default: state <= ST_DONE;
         endcase
      end
   end

   AST_REF_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
      ref_cnt <= REF_W'(NUM_REFRESH)); // R5
   AST_DONE_STATE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DONE) |=> (state == ST_DONE)); // R8

endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
   import sdram_init_pkg::*;
#(
   parameter int unsigned ROW_W         = 13,
   parameter int unsigned BANK_W        = 2,
   parameter int unsigned DQM_W         = 4,
   parameter int unsigned MODE_VAL      = 'h032,
   parameter bit          PRECHARGE_ALL = 1'b1,
   parameter int unsigned AP_BIT        = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  init_state_e       state,
   input  logic [BANK_W-1:0] bank,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0]  addr,
   output logic [DQM_W-1:0]  dqm,
   output logic              done
);

   sdram_cmd_e        cmd_q, cmd_nx;
   logic [ROW_W-1:0]  addr_nx, pre_addr;
   logic [BANK_W-1:0] ba_nx;

   if (PRECHARGE_ALL) begin : g_ap_all
      assign pre_addr = ROW_W'(1) << AP_BIT;
   end else begin : g_ap_bank
      assign pre_addr = '0;
   end

   always_comb begin
      cmd_nx  = CMD_NOP;
      addr_nx = '0;
      ba_nx   = '0;
      case (state)
         ST_PRE: begin
            cmd_nx  = CMD_PRE;
            addr_nx = pre_addr;
            ba_nx   = bank;
         end
         ST_REF: cmd_nx = CMD_REF;
         ST_MRS: begin
            cmd_nx  = CMD_MRS;
            addr_nx = ROW_W'(MODE_VAL);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q <= CMD_NOP;
         addr  <= '0;
         ba    <= '0;
         cke   <= 1'b1;
         dqm   <= '1;
         done  <= 1'b0;
      end else begin
         cmd_q <= cmd_nx;
         addr  <= addr_nx;
         ba    <= ba_nx;
         cke   <= 1'b1;
         dqm   <= '1;
         done  <= (state == ST_DONE);
      end
   end

   assign cs_n  = cmd_q[3];
   assign ras_n = cmd_q[2];
   assign cas_n = cmd_q[1];
   assign we_n  = cmd_q[0];

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int unsigned CLK_MHZ       = 250,
   parameter int unsigned HOLD_NS       = 200000,
   parameter int unsigned TRP_NS        = 20,
   parameter int unsigned TRFC_NS       = 70,
   parameter int unsigned TMRD_CYC      = 2,
   parameter int unsigned NUM_REFRESH   = 8,
   parameter bit          PRECHARGE_ALL = 1'b1,
   parameter int unsigned ROW_W         = 13,
   parameter int unsigned BANK_W        = 2,
   parameter int unsigned DQM_W         = 4,
   parameter int unsigned MODE_VAL      = 'h032
) (
   input  logic              clk,
   input  logic              rst,
   output logic              sdram_cke,
   output logic              sdram_cs_n,
   output logic              sdram_ras_n,
   output logic              sdram_cas_n,
   output logic              sdram_we_n,
   output logic [BANK_W-1:0] sdram_ba,
   output logic [ROW_W-1:0]  sdram_addr,
   output logic [DQM_W-1:0]  sdram_dqm,
   output logic              init_done
);

   localparam int unsigned HOLD_CYC = ns_to_cyc(HOLD_NS, CLK_MHZ);
   localparam int unsigned TRP_CYC  = ns_to_cyc(TRP_NS, CLK_MHZ);
   localparam int unsigned TRFC_CYC = ns_to_cyc(TRFC_NS, CLK_MHZ);
   localparam int unsigned AP_BIT   = 10;

   if (NUM_REFRESH < 8) begin : g_chk_refresh
      $error("at least eight refresh commands are required");
   end
   if (HOLD_CYC < 2 || TRP_CYC < 2 || TRFC_CYC < 2 || TMRD_CYC < 2) begin : g_chk_timing
      $error("every wait must span at least two cycles");
   end
   if (ROW_W <= AP_BIT || BANK_W < 1 || DQM_W < 1) begin : g_chk_geometry
      $error("pin widths out of range");
   end
   if ((64'(MODE_VAL) >> ROW_W) != 64'd0) begin : g_chk_mode
      $error("mode value wider than the address bus");
   end

   init_state_e       state;
   logic [BANK_W-1:0] bank;

   sdram_init_fsm #(
      .HOLD_CYC      (HOLD_CYC),
      .TRP_CYC       (TRP_CYC),
      .TRFC_CYC      (TRFC_CYC),
      .TMRD_CYC      (TMRD_CYC),
      .NUM_REFRESH   (NUM_REFRESH),
      .PRECHARGE_ALL (PRECHARGE_ALL),
      .BANK_W        (BANK_W)
   ) u_fsm (
      .clk   (clk),
      .rst   (rst),
      .state (state),
      .bank  (bank)
   );

   sdram_init_pins #(
      .ROW_W         (ROW_W),
      .BANK_W        (BANK_W),
      .DQM_W         (DQM_W),
      .MODE_VAL      (MODE_VAL),
      .PRECHARGE_ALL (PRECHARGE_ALL),
      .AP_BIT        (AP_BIT)
   ) u_pins (
      .clk   (clk),
      .rst   (rst),
      .state (state),
      .bank  (bank),
      .cke   (sdram_cke),
      .cs_n  (sdram_cs_n),
      .ras_n (sdram_ras_n),
      .cas_n (sdram_cas_n),
      .we_n  (sdram_we_n),
      .ba    (sdram_ba),
      .addr  (sdram_addr),
      .dqm   (sdram_dqm),
      .done  (init_done)
   );

   // pin-level spacing monitors for the assertions below
   logic [3:0]  pin_cmd;
   int unsigned since_pre, since_ref, since_mrs, refs_seen;
   logic        seen_pre, seen_ref, seen_mrs;

   assign pin_cmd = {sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n};

   function automatic int unsigned sat_inc(input int unsigned v);
      return (v == 32'hFFFF_FFFF) ? v : v + 1;
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         since_pre <= 0;
         since_ref <= 0;
         since_mrs <= 0;
         refs_seen <= 0;
         seen_pre  <= 1'b0;
         seen_ref  <= 1'b0;
         seen_mrs  <= 1'b0;
      end else begin
         since_pre <= (pin_cmd == CMD_PRE) ? 1 : sat_inc(since_pre);
         since_ref <= (pin_cmd == CMD_REF) ? 1 : sat_inc(since_ref);
         since_mrs <= (pin_cmd == CMD_MRS) ? 1 : sat_inc(since_mrs);
         if (pin_cmd == CMD_REF) refs_seen <= sat_inc(refs_seen);
         if (pin_cmd == CMD_PRE) seen_pre <= 1'b1;
         if (pin_cmd == CMD_REF) seen_ref <= 1'b1;
         if (pin_cmd == CMD_MRS) seen_mrs <= 1'b1;
      end
   end

   AST_HOLD_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
      (state == ST_HOLD) |=> (pin_cmd == CMD_NOP)); // R2
   AST_FIRST_REF_AFTER_TRP: assert property (@(posedge clk) disable iff (rst)
      (pin_cmd == CMD_REF && !seen_ref) |-> (seen_pre && since_pre >= TRP_CYC)); // R4
   AST_REF_SPACING: assert property (@(posedge clk) disable iff (rst)
      (pin_cmd == CMD_REF && seen_ref) |-> (since_ref >= TRFC_CYC)); // R6
   AST_MRS_AFTER_BURST: assert property (@(posedge clk) disable iff (rst)
      (pin_cmd == CMD_MRS) |-> (refs_seen == NUM_REFRESH)); // R7
   AST_DONE_AFTER_TMRD: assert property (@(posedge clk) disable iff (rst)
      $rose(init_done) |-> (seen_mrs && since_mrs >= TMRD_CYC)); // R8
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done); // R8

endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

   localparam int unsigned MHZ     = 250;
   localparam int unsigned HOLD_NS = 4000;
   localparam int unsigned TRP_NS  = 20;
   localparam int unsigned TRFC_NS = 70;
   localparam int unsigned TMRD    = 2;
   localparam int unsigned H       = (HOLD_NS * MHZ + 999) / 1000;
   localparam int unsigned TRP     = (TRP_NS * MHZ + 999) / 1000;
   localparam int unsigned TRFC    = (TRFC_NS * MHZ + 999) / 1000;
   localparam int unsigned NREF0   = 8;
   localparam int unsigned NREF1   = 9;
   localparam int unsigned MODE0   = 'h032;
   localparam int unsigned MODE1   = 'h023;
   localparam logic [3:0]  C_NOP   = 4'b0111;
   localparam logic [3:0]  C_PRE   = 4'b0010;
   localparam logic [3:0]  C_REF   = 4'b0001;
   localparam logic [3:0]  C_MRS   = 4'b0000;
   localparam logic [3:0]  C_DONE  = 4'b1111;

   typedef struct {
      int unsigned cyc;
      logic [3:0]  cmd;
      logic [12:0] addr;
      logic [1:0]  ba;
      logic        chk_ab;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int fails  = 0;
   exp_t q0[$];
   exp_t q1[$];
   logic prev_done [2];
   int   mask_bad  [2];

   logic        cke0, cs0, ras0, cas0, we0, done0;
   logic        cke1, cs1, ras1, cas1, we1, done1;
   logic [1:0]  ba0, ba1;
   logic [12:0] addr0, addr1;
   logic [3:0]  dqm0, dqm1;

   sdram_init_seq #(
      .CLK_MHZ (MHZ), .HOLD_NS (HOLD_NS), .TRP_NS (TRP_NS), .TRFC_NS (TRFC_NS),
      .TMRD_CYC (TMRD), .NUM_REFRESH (NREF0), .PRECHARGE_ALL (1'b1), .MODE_VAL (MODE0)
   ) u_sdram_init_seq (
      .clk (clk), .rst (rst), .sdram_cke (cke0), .sdram_cs_n (cs0), .sdram_ras_n (ras0),
      .sdram_cas_n (cas0), .sdram_we_n (we0), .sdram_ba (ba0), .sdram_addr (addr0),
      .sdram_dqm (dqm0), .init_done (done0)
   );

   sdram_init_seq #(
      .CLK_MHZ (MHZ), .HOLD_NS (HOLD_NS), .TRP_NS (TRP_NS), .TRFC_NS (TRFC_NS),
      .TMRD_CYC (TMRD), .NUM_REFRESH (NREF1), .PRECHARGE_ALL (1'b0), .MODE_VAL (MODE1)
   ) u_sdram_init_seq_pb (
      .clk (clk), .rst (rst), .sdram_cke (cke1), .sdram_cs_n (cs1), .sdram_ras_n (ras1),
      .sdram_cas_n (cas1), .sdram_we_n (we1), .sdram_ba (ba1), .sdram_addr (addr1),
      .sdram_dqm (dqm1), .init_done (done1)
   );

   function automatic string tag_of(input logic [3:0] c);
      case (c)
         C_PRE:   return "R3";
         C_REF:   return "R4/R6";
         C_MRS:   return "R7";
         C_DONE:  return "R8";
         default: return "R2";
      endcase
   endfunction

   task automatic push(input int i, input int unsigned t, input logic [3:0] c,
                       input logic [12:0] a, input logic [1:0] b, input logic chk);
      exp_t e;
      e.cyc = t; e.cmd = c; e.addr = a; e.ba = b; e.chk_ab = chk;
      if (i == 0) q0.push_back(e);
      else        q1.push_back(e);
   endtask

   // driver: predicted pin events for one run starting at cycle base
   task automatic build(input int i, input int unsigned base, input bit pre_all,
                        input int unsigned nref, input int unsigned mode);
      int unsigned last_pre, r0, mrs;
      if (pre_all) begin
         push(i, base + H + 1, C_PRE, 13'h400, 2'd0, 1'b1);         // R2 R3
         last_pre = base + H + 1;
      end else begin
         for (int k = 0; k < 4; k++)
            push(i, base + H + 1 + k, C_PRE, 13'h000, 2'(k), 1'b1);  // R3
         last_pre = base + H + 4;
      end
      r0 = last_pre + TRP;                                           // R4
      for (int k = 0; k < int'(nref); k++)
         push(i, r0 + k * TRFC, C_REF, 13'h0, 2'd0, 1'b0);           // R5 R6
      mrs = r0 + nref * TRFC;
      push(i, mrs, C_MRS, 13'(mode), 2'd0, 1'b1);                    // R7
      push(i, mrs + TMRD, C_DONE, 13'h0, 2'd0, 1'b0);                // R8
   endtask

   task automatic score(input int i, input logic [3:0] c, input logic [12:0] a, input logic [1:0] b);
      exp_t e;
      checks++;
      if ((i == 0 && q0.size() == 0) || (i == 1 && q1.size() == 0)) begin
         fails++;
         $display("FAIL %s inst %0d: unexpected event cmd=%b at cycle %0d, expected none",
                  tag_of(c), i, c, cyc);
         return;
      end
      e = (i == 0) ? q0.pop_front() : q1.pop_front();
      if (e.cyc != cyc || e.cmd != c || (e.chk_ab && (e.addr != a || e.ba != b))) begin
         fails++;
         $display("FAIL %s inst %0d: got cmd=%b addr=%h ba=%0d cycle=%0d, expected cmd=%b addr=%h ba=%0d cycle=%0d",
                  tag_of(e.cmd), i, c, a, b, cyc, e.cmd, e.addr, e.ba, e.cyc);
      end
   endtask

   // monitor: compares every non-NOP command and the ready edge
   task automatic monitor(input int i, input logic [3:0] c, input logic [12:0] a,
                          input logic [1:0] b, input logic d, input logic ck, input logic [3:0] m);
      if (rst) begin
         prev_done[i] = 1'b0;
         return;
      end
      if (!ck || m != 4'hF) mask_bad[i]++;
      if (c != C_NOP) score(i, c, a, b);
      if (d && !prev_done[i]) score(i, C_DONE, 13'h0, 2'd0);
      if (!d && prev_done[i]) begin
         checks++; fails++;
         $display("FAIL R8 inst %0d: init_done fell at cycle %0d, got 0 expected 1", i, cyc);
      end
      prev_done[i] = d;
   endtask

   always @(negedge clk) begin
      monitor(0, {cs0, ras0, cas0, we0}, addr0, ba0, done0, cke0, dqm0);
      monitor(1, {cs1, ras1, cas1, we1}, addr1, ba1, done1, cke1, dqm1);
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_eq(input string tag, input int unsigned got, input int unsigned exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic check_idle(input string tag);
      expect_eq({tag, " inst0 cmd NOP"}, {cs0, ras0, cas0, we0}, C_NOP);
      expect_eq({tag, " inst1 cmd NOP"}, {cs1, ras1, cas1, we1}, C_NOP);
      expect_eq({tag, " masks and cke high"}, {cke0, dqm0, cke1, dqm1}, 10'h3FF);
      expect_eq({tag, " done low"}, {done0, done1}, 0);
   endtask

   task automatic run_and_finish(input string tag);
      tick(H + 400);
      expect_eq({tag, " R5 inst0 events left"}, q0.size(), 0);
      expect_eq({tag, " R5 inst1 events left"}, q1.size(), 0);
      expect_eq({tag, " R8 done held"}, {done0, done1}, 2'b11);
      expect_eq({tag, " R8 bus NOP after done"}, {cs0, ras0, cas0, we0, cs1, ras1, cas1, we1}, 8'h77);
   endtask

   task automatic release_reset();
      int unsigned base;
      rst = 1'b0;
      base = cyc;
      build(0, base, 1'b1, NREF0, MODE0);
      build(1, base, 1'b0, NREF1, MODE1);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      mask_bad[0] = 0; mask_bad[1] = 0;
      prev_done[0] = 1'b0; prev_done[1] = 1'b0;
      rst = 1'b1;
      tick(3);
      check_idle("R1 in reset");
      release_reset();
      run_and_finish("first run");

      // R9: reset while done is high
      rst = 1'b1;
      tick(2);
      q0.delete(); q1.delete();
      check_idle("R9 reset after done");
      release_reset();

      // R9: reset in the middle of the refresh burst
      tick(H + 60);
      rst = 1'b1;
      tick(1);
      q0.delete(); q1.delete();
      check_idle("R9 reset in refresh burst");
      tick(1);
      release_reset();
      run_and_finish("restart run");

      expect_eq("R1 cke/dqm dropped inst0", mask_bad[0], 0);
      expect_eq("R1 cke/dqm dropped inst1", mask_bad[1], 0);
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
   end

endmodule